// File: doc/BRIEF.md
# Dual-Stream PID Drop Filter

This block sits on two byte-wide MPEG transport stream paths and decides, packet by packet, whether each 188-byte packet travels on or vanishes. Every stream owns a bitmap with one bit per 13-bit PID value, held on chip as 1024 bytes. A set bit marks the PID as unwanted and the whole packet is suppressed. A clear bit lets it through. PIDs 0x00 through 0x1F always pass, whatever the bitmap holds, so the table-carrying PIDs can never be filtered away.

Software maintains the bitmaps through a three-register host port. Two index registers select a filter and a byte within it, and a data register reads or writes that byte, so one PID bit can be flipped by read-modify-write. Each stream is delayed by three input bytes, so the verdict on a packet is known before its first byte leaves. Stream lookups always win the bitmap. A host access that collides with a lookup on the same filter waits one cycle.

Top module: `pid_filter`

## Requirements
- R1: After reset every output valid and sync is low, and every bitmap byte of both filters reads back as 0x00, so all PIDs pass.
- R2: The PID is bits 4:0 of packet byte 1 (PID bits 12:8) followed by all of byte 2 (PID bits 7:0). Its bitmap byte index is PID[12:3] and its bit within that byte is PID[2:0]. A 1 drops all 188 bytes of the packet. A 0 forwards all 188 bytes unchanged and in order.
- R3: Packets with PID 0x00 to 0x1F are forwarded even when their bitmap bits are 1.
- R4: A host write with hostSel=0 loads index bits 7:0. A write with hostSel=1 loads index bits 9:8 from data bits 1:0 and selects the filter from data bit 2 (0 = stream 0, 1 = stream 1).
- R5: A host write with hostSel=2 stores hostWdata into the selected filter byte. A read with hostSel=2 places that byte on hostRdata within three cycles and holds it there until the next read. The index and filter are captured when the request is made.
- R6: Each stream is filtered only by its own bitmap.
- R7: A packet whose first byte (marked by inSync) is not 0x47 is dropped entirely. Input bytes that belong to no packet never appear at the output.
- R8: A forwarded byte leaves on the clock edge that accepts the third later input byte of the same stream. outSync is high only on a packet's first byte, and outValid is high only in the cycle after an input valid.
- R9: A host access is never granted in the cycle in which the same filter does a stream lookup. That lookup uses the bitmap content from before the host write, and the stream is not delayed. Every host data access completes within two cycles of its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 2x8 | Input byte per stream |
| inSync | input | 2 | First byte of a packet, per stream |
| inValid | input | 2 | Input byte present, per stream |
| outData | output | 2x8 | Output byte per stream |
| outSync | output | 2 | First byte of a forwarded packet |
| outValid | output | 2 | Output byte present |
| hostSel | input | 2 | Register select: 0 index low, 1 index high/filter, 2 bitmap data |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (data register) |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Bitmap byte returned by the last read |

## Verification
The bound checker watches the cycle-level rules on every clock: output only after an input byte, sync only on a valid byte, no host grant to a filter while it does a lookup, bounded completion of host data requests, and the read register holding steady between reads. The drop and pass decisions cannot be seen from single cycles. These include whole-packet suppression, the always-pass range below 0x20, header rejection, per-stream bitmap isolation, and a lookup that sees the value from before a colliding write. The bench's scenarios show them by comparing complete forwarded byte sequences, sync flags included, against lists it builds itself.

// File: rtl/pidfilt_pkg.sv
package pidfilt_pkg;
  localparam int NUM_STREAMS   = 2;
  localparam int PID_W         = 13;
  localparam int BIT_SEL_W     = 3;
  localparam int IDX_W         = PID_W - BIT_SEL_W;
  localparam int MAP_BYTES     = 1 << IDX_W;
  localparam int HI_W          = IDX_W - 8;
  localparam int FSEL_W        = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;
  localparam int RESERVED_PIDS = 32;
  localparam int HDR_DELAY     = 3;
  localparam logic [7:0] SYNC_BYTE = 8'h47;

  typedef enum logic [1:0] {
    SEL_IDX_LO = 2'd0,
    SEL_IDX_HI = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_NONE   = 2'd3
  } hostSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [NUM_STREAMS-1:0] shift;
    logic [NUM_STREAMS-1:0] member;
    logic [NUM_STREAMS-1:0] lookup;
    logic                   hostWe;
    logic                   hostRe;
    logic [FSEL_W-1:0]      hostFilt;
    logic [IDX_W-1:0]       hostIdx;
    logic [7:0]             hostWdata;
  } strobes_t;
endpackage

// File: rtl/pidfilt_ctrl.sv
module pidfilt_ctrl
  import pidfilt_pkg::*;
#(
  parameter int PKT_LEN = 188
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_STREAMS-1:0] inSync,
  input  logic [NUM_STREAMS-1:0] inValid,
  input  logic [1:0]             hostSel,
  input  logic                   hostWr,
  input  logic                   hostRd,
  input  logic [7:0]             hostWdata,
  output strobes_t               stb
);
  localparam int CNT_W = $clog2(PKT_LEN);

  logic [NUM_STREAMS-1:0]            inPkt;
  logic [NUM_STREAMS-1:0][CNT_W-1:0] byteCnt;
  logic [NUM_STREAMS-1:0]            lookupVec;
  logic [NUM_STREAMS-1:0]            memberVec;

  // per-stream packet framing
  for (genvar g = 0; g < NUM_STREAMS; g++) begin : gFrame
    always_ff @(posedge clk) begin
      if (!rstN) begin
        inPkt[g]   <= 1'b0;
        byteCnt[g] <= '0;
      end else if (inValid[g]) begin
        if (inSync[g]) begin
          inPkt[g]   <= 1'b1;
          byteCnt[g] <= CNT_W'(1);
        end else if (inPkt[g]) begin
          if (byteCnt[g] == CNT_W'(PKT_LEN - 1)) inPkt[g] <= 1'b0;
          byteCnt[g] <= byteCnt[g] + CNT_W'(1);
        end
      end
    end
    assign lookupVec[g] = inValid[g] && !inSync[g] && inPkt[g] && (byteCnt[g] == CNT_W'(2));
    assign memberVec[g] = inValid[g] && (inSync[g] || inPkt[g]);
  end

  // host registers and one-deep pending access
  hostSel_e          selE;
  logic [7:0]        idxLo;
  logic [HI_W-1:0]   idxHi;
  logic [FSEL_W-1:0] filtSel;
  logic              pend, pendRd;
  logic [IDX_W-1:0]  pendIdx;
  logic [FSEL_W-1:0] pendFilt;
  logic [7:0]        pendData;
  logic              grant;

  assign selE  = hostSel_e'(hostSel);
  assign grant = pend && !lookupVec[pendFilt];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxLo    <= '0;
      idxHi    <= '0;
      filtSel  <= '0;
      pend     <= 1'b0;
      pendRd   <= 1'b0;
      pendIdx  <= '0;
      pendFilt <= '0;
      pendData <= '0;
    end else begin
      if (grant) pend <= 1'b0;
      if (hostWr && selE == SEL_IDX_LO) idxLo <= hostWdata;
      if (hostWr && selE == SEL_IDX_HI) begin
        idxHi   <= hostWdata[HI_W-1:0];
        filtSel <= hostWdata[HI_W +: FSEL_W];
      end
      if ((hostWr || hostRd) && selE == SEL_DATA) begin
        pend     <= 1'b1;
        pendRd   <= !hostWr;
        pendIdx  <= {idxHi, idxLo};
        pendFilt <= filtSel;
        pendData <= hostWdata;
      end
    end
  end

  always_comb begin
    stb.shift     = inValid;
    stb.member    = memberVec;
    stb.lookup    = lookupVec;
    stb.hostWe    = grant && !pendRd;
    stb.hostRe    = grant && pendRd;
    stb.hostFilt  = pendFilt;
    stb.hostIdx   = pendIdx;
    stb.hostWdata = pendData;
  end
endmodule

// File: rtl/pidfilt_datapath.sv
module pidfilt_datapath
  import pidfilt_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  strobes_t                    stb,
  input  logic [NUM_STREAMS-1:0][7:0] inData,
  input  logic [NUM_STREAMS-1:0]      inSync,
  output logic [NUM_STREAMS-1:0][7:0] outData,
  output logic [NUM_STREAMS-1:0]      outSync,
  output logic [NUM_STREAMS-1:0]      outValid,
  output logic [7:0]                  hostRdata
);
  logic [7:0] bitmap [NUM_STREAMS][MAP_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int f = 0; f < NUM_STREAMS; f++)
        for (int i = 0; i < MAP_BYTES; i++)
          bitmap[f][i] <= '0;
      hostRdata <= '0;
    end else begin
      if (stb.hostWe) bitmap[stb.hostFilt][stb.hostIdx] <= stb.hostWdata;
      if (stb.hostRe) hostRdata <= bitmap[stb.hostFilt][stb.hostIdx];
    end
  end

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : gLane
    logic [7:0]           dly [HDR_DELAY];
    logic [HDR_DELAY-1:0] dlyMem, dlySync;
    logic                 keep, oValid, oSync;
    logic [7:0]           oData;
    logic [PID_W-1:0]     pid;
    logic                 mapBit, pass;

    // at a lookup dly[0] holds header byte 1 and dly[1] holds byte 0
    assign pid    = {dly[0][PID_W-9:0], inData[g]};
    assign mapBit = bitmap[g][pid[PID_W-1:BIT_SEL_W]][pid[BIT_SEL_W-1:0]];
    assign pass   = (dly[1] == SYNC_BYTE) &&
                    ((pid < PID_W'(RESERVED_PIDS)) || !mapBit);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int d = 0; d < HDR_DELAY; d++) dly[d] <= '0;
        dlyMem  <= '0;
        dlySync <= '0;
        keep    <= 1'b0;
        oValid  <= 1'b0;
        oSync   <= 1'b0;
        oData   <= '0;
      end else begin
        if (stb.shift[g]) begin
          dly[0] <= inData[g];
          for (int d = 1; d < HDR_DELAY; d++) dly[d] <= dly[d-1];
          dlyMem  <= {dlyMem[HDR_DELAY-2:0], stb.member[g]};
          dlySync <= {dlySync[HDR_DELAY-2:0], inSync[g]};
          oData   <= dly[HDR_DELAY-1];
          oValid  <= dlyMem[HDR_DELAY-1] && keep;
          oSync   <= dlyMem[HDR_DELAY-1] && keep && dlySync[HDR_DELAY-1];
        end else begin
          oValid <= 1'b0;
          oSync  <= 1'b0;
        end
        if (stb.lookup[g]) keep <= pass;
      end
    end

    assign outData[g]  = oData;
    assign outValid[g] = oValid;
    assign outSync[g]  = oSync;
  end
endmodule

// File: rtl/pid_filter.sv
module pid_filter
  import pidfilt_pkg::*;
#(
  parameter int PKT_LEN = 188
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_STREAMS-1:0][7:0] inData,
  input  logic [NUM_STREAMS-1:0]      inSync,
  input  logic [NUM_STREAMS-1:0]      inValid,
  output logic [NUM_STREAMS-1:0][7:0] outData,
  output logic [NUM_STREAMS-1:0]      outSync,
  output logic [NUM_STREAMS-1:0]      outValid,
  input  logic [1:0]                  hostSel,
  input  logic                        hostWr,
  input  logic                        hostRd,
  input  logic [7:0]                  hostWdata,
  output logic [7:0]                  hostRdata
);
  strobes_t stb;

  pidfilt_ctrl #(.PKT_LEN(PKT_LEN)) u_ctrl (
    .clk, .rstN, .inSync, .inValid, .hostSel, .hostWr, .hostRd, .hostWdata, .stb
  );

  pidfilt_datapath u_dp (
    .clk, .rstN, .stb, .inData, .inSync, .outData, .outSync, .outValid, .hostRdata
  );
endmodule

// File: rtl/pidfilt_checker.sv
module pidfilt_checker
  import pidfilt_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_STREAMS-1:0] inValid,
  input logic [NUM_STREAMS-1:0] outValid,
  input logic [NUM_STREAMS-1:0] outSync,
  input logic [1:0]             hostSel,
  input logic                   hostWr,
  input logic                   hostRd,
  input logic [7:0]             hostRdata,
  input strobes_t               stb
);
  logic dataReq, anyGrant;
  assign dataReq  = (hostWr || hostRd) && (hostSel == 2'd2);
  assign anyGrant = stb.hostWe || stb.hostRe;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (outValid == '0)); // R1

  AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    anyGrant |-> !stb.lookup[stb.hostFilt]); // R9

  AST_HOST_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dataReq, 2) && !$past(anyGrant)) |-> anyGrant); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.hostRe) |-> $stable(hostRdata)); // R5

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : gLaneChk
    AST_OUT_AFTER_IN: assert property (@(posedge clk) disable iff (!rstN)
      outValid[g] |-> $past(inValid[g])); // R8

    AST_SYNC_ON_VALID: assert property (@(posedge clk) disable iff (!rstN)
      outSync[g] |-> outValid[g]); // R8

    AST_LOOKUP_SPACING: assert property (@(posedge clk) disable iff (!rstN)
      stb.lookup[g] |=> !stb.lookup[g]); // R2
  end
endmodule

bind pid_filter pidfilt_checker u_chk (
  .clk, .rstN, .inValid, .outValid, .outSync, .hostSel, .hostWr, .hostRd,
  .hostRdata, .stb(stb)
);

// File: tb/pid_filter_test.sv
module pid_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int PKT = 188;

  logic            clk = 1'b0;
  logic            rstN;
  logic [1:0][7:0] inData;
  logic [1:0]      inSync, inValid;
  logic [1:0][7:0] outData;
  logic [1:0]      outSync, outValid;
  logic [1:0]      hostSel;
  logic            hostWr, hostRd;
  logic [7:0]      hostWdata, hostRdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [8:0] got0[$], got1[$], exp0[$], exp1[$];

  pid_filter uut (
    .clk, .rstN, .inData, .inSync, .inValid, .outData, .outSync, .outValid,
    .hostSel, .hostWr, .hostRd, .hostWdata, .hostRdata
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      if (outValid[0]) got0.push_back({outSync[0], outData[0]});
      if (outValid[1]) got1.push_back({outSync[1], outData[1]});
    end
  end

  task automatic chk(input string req, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic regWr(input logic [1:0] sel, input logic [7:0] v);
    @(negedge clk); hostSel = sel; hostWdata = v; hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic setIndex(input int f, input int idx);
    regWr(2'd0, 8'(idx));
    regWr(2'd1, 8'(((f & 1) << 2) | ((idx >> 8) & 3)));
  endtask

  task automatic hostWriteByte(input int f, input int idx, input logic [7:0] v);
    setIndex(f, idx);
    regWr(2'd2, v);
    repeat (2) @(negedge clk);
  endtask

  task automatic hostReadByte(input int f, input int idx, output logic [7:0] v);
    setIndex(f, idx);
    @(negedge clk); hostSel = 2'd2; hostRd = 1'b1;
    @(negedge clk); hostRd = 1'b0;
    repeat (3) @(negedge clk);
    v = hostRdata;
  endtask

  task automatic drv(input int s, input logic [7:0] b, input logic sy);
    @(negedge clk);
    inData[s] = b; inSync[s] = sy; inValid[s] = 1'b1;
  endtask

  task automatic sendPacket(input int s, input int pid, input int seed, input logic [7:0] b0,
                            input bit keep, input int hookByte, input logic [7:0] hookData);
    for (int k = 0; k < PKT; k++) begin
      logic [7:0] b;
      if (k == 0)      b = b0;
      else if (k == 1) b = 8'((pid >> 8) & 8'h1F);
      else if (k == 2) b = 8'(pid);
      else             b = 8'(k * 7 + seed);
      drv(s, b, k == 0);
      if (k == hookByte) begin hostSel = 2'd2; hostWdata = hookData; hostWr = 1'b1; end
      else if (hookByte >= 0) hostWr = 1'b0;
      if (keep) begin
        if (s == 0) exp0.push_back({k == 0, b});
        else        exp1.push_back({k == 0, b});
      end
    end
  endtask

  task automatic flush(input int s);
    for (int k = 0; k < 3; k++) drv(s, 8'hFF, 1'b0);
    @(negedge clk); inValid[s] = 1'b0; inSync[s] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic compareStream(input int s, input string req);
    int n, m, bad;
    bad = -1;
    n = (s == 0) ? got0.size() : got1.size();
    m = (s == 0) ? exp0.size() : exp1.size();
    for (int i = 0; i < n && i < m; i++) begin
      logic [8:0] a, e;
      a = (s == 0) ? got0[i] : got1[i];
      e = (s == 0) ? exp0[i] : exp1[i];
      if (bad < 0 && a != e) bad = i;
    end
    if (n != m) chk(req, 1'b0, n, m);
    else if (bad >= 0) chk(req, 1'b0, (s == 0) ? got0[bad] : got1[bad],
                           (s == 0) ? exp0[bad] : exp1[bad]);
    else chk(req, 1'b1, n, m);
    if (s == 0) begin got0.delete(); exp0.delete(); end
    else begin got1.delete(); exp1.delete(); end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 outValid after reset", outValid == 2'b00, outValid, 0);
    hostReadByte(0, 0, v);     chk("R1 filter0 byte 0x000", v == 8'h00, v, 0);
    hostReadByte(0, 1023, v);  chk("R1 filter0 byte 0x3FF", v == 8'h00, v, 0);
    hostReadByte(1, 512, v);   chk("R1 filter1 byte 0x200", v == 8'h00, v, 0);
    hostReadByte(1, 37, v);    chk("R1 filter1 byte 0x025", v == 8'h00, v, 0);
  endtask

  task automatic t_hostRegs();
    logic [7:0] v;
    hostWriteByte(1, 12'h2A5, 8'h5A);
    hostWriteByte(0, 12'h2A5, 8'hC3);
    hostReadByte(1, 12'h2A5, v); chk("R4 filter1 select", v == 8'h5A, v, 8'h5A);
    hostReadByte(0, 12'h2A5, v); chk("R5 filter0 readback", v == 8'hC3, v, 8'hC3);
    // read-modify-write of a single PID bit
    hostReadByte(0, 12'h2A5, v);
    hostWriteByte(0, 12'h2A5, v | 8'h04);
    hostReadByte(0, 12'h2A5, v); chk("R5 read-modify-write", v == 8'hC7, v, 8'hC7);
  endtask

  task automatic t_dropPass();
    // PID 0x1234: byte 0x246, bit 4
    hostWriteByte(0, 12'h246, 8'h10);
    sendPacket(0, 13'h1234, 3, 8'h47, 1'b0, -1, 8'h00);
    sendPacket(0, 13'h1235, 5, 8'h47, 1'b1, -1, 8'h00);
    sendPacket(0, 13'h0100, 9, 8'h47, 1'b1, -1, 8'h00);
    sendPacket(0, 13'h1234, 11, 8'h47, 1'b0, -1, 8'h00);
    flush(0);
    compareStream(0, "R2 R8 drop/pass sequence");
  endtask

  task automatic t_reserved();
    hostWriteByte(0, 0, 8'hFF);
    hostWriteByte(0, 3, 8'hFF);
    hostWriteByte(0, 4, 8'h01);
    sendPacket(0, 13'h0005, 1, 8'h47, 1'b1, -1, 8'h00);
    sendPacket(0, 13'h001F, 2, 8'h47, 1'b1, -1, 8'h00);
    sendPacket(0, 13'h0020, 4, 8'h47, 1'b0, -1, 8'h00);
    sendPacket(0, 13'h0021, 6, 8'h47, 1'b1, -1, 8'h00);
    flush(0);
    compareStream(0, "R3 always-pass PIDs");
  endtask

  task automatic t_badHeader();
    for (int k = 0; k < 5; k++) drv(1, 8'(8'h30 + k), 1'b0);
    sendPacket(1, 13'h0101, 7, 8'h46, 1'b0, -1, 8'h00);
    sendPacket(1, 13'h0101, 8, 8'h47, 1'b1, -1, 8'h00);
    flush(1);
    compareStream(1, "R7 bad header and stray bytes");
  endtask

  task automatic t_streams();
    // PID 0x0400: byte 0x080, bit 0, blocked on filter 1 only
    hostWriteByte(1, 12'h080, 8'h01);
    fork
      sendPacket(0, 13'h0400, 20, 8'h47, 1'b1, -1, 8'h00);
      sendPacket(1, 13'h0400, 21, 8'h47, 1'b0, -1, 8'h00);
    join
    fork
      sendPacket(0, 13'h0401, 22, 8'h47, 1'b1, -1, 8'h00);
      sendPacket(1, 13'h0401, 23, 8'h47, 1'b1, -1, 8'h00);
    join
    fork flush(0); flush(1); join
    compareStream(0, "R6 stream0 own bitmap");
    compareStream(1, "R6 stream1 own bitmap");
  endtask

  task automatic t_collision();
    logic [7:0] v;
    // PID 0x0777: byte 0x0EE, bit 7; write lands during this packet's lookup
    setIndex(0, 12'h0EE);
    sendPacket(0, 13'h0777, 30, 8'h47, 1'b1, 1, 8'h80);
    sendPacket(0, 13'h0777, 31, 8'h47, 1'b0, -1, 8'h00);
    flush(0);
    compareStream(0, "R9 lookup wins, old value used");
    hostReadByte(0, 12'h0EE, v); chk("R9 deferred write landed", v == 8'h80, v, 8'h80);
  endtask

  initial begin
    rstN = 1'b0; inData = '0; inSync = '0; inValid = '0;
    hostSel = '0; hostWr = 1'b0; hostRd = 1'b0; hostWdata = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_hostRegs();
    t_dropPass();
    t_reserved();
    t_badHeader();
    t_streams();
    t_collision();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule